// File: doc/BRIEF.md
# Vectored Peripheral Interrupt Controller

This block collects interrupt requests from up to 32 on-chip peripheral sources and presents them to a processor core as a single level-sensitive interrupt line. Each request is caught in a pending register, where it stays until software clears it. A per-source enable mask and a global enable decide whether a pending request reaches the core. The core is not told which source raised the request.

To learn which source raised the request, software writes the acknowledge bit of the vector register. The controller then freezes the number of the winning source into that register, and software reads the number back. The winner is chosen in two steps. A configurable favoured source wins whenever it is active. Otherwise the highest-numbered source wins.

After servicing the source, software writes a 1 to that source's bit in the in-service register. If software disables a source at the moment that source is raising its interrupt, the request would otherwise be lost. In that case the controller keeps the line asserted and hands out vector 0 as an error vector on the next acknowledge.

Top module: `vpic_top`

Register map, selected by `bus_addr`:

| Address | Register | Write | Read |
|---|---|---|---|
| 0 | Configuration | bit 0 is the global enable, bits [12:8] select the favoured source, bits [15:13] hold the priority level | all fields |
| 1 | Enable mask | bit N set to 1 enables source N | the mask |
| 2 | In-service | writing a 1 to bit N clears source N | the pending bits |
| 3 | Vector | a 1 in bit 0 acknowledges | the vector in bits [15:11], all other bits 0 |

## Requirements
- R1: After reset, the configuration register, the mask, the pending bits and the vector all read as 0, and `irq_out` is low.
- R2: A source request that is high for one clock sets its bit in the pending register. The request is latched whether or not the source is enabled in the mask. The bit stays set after the request drops, until software clears it.
- R3: `irq_out` is high while the global enable is 1 and any enabled source is pending. It is also high in that case while the error latch is set.
- R4: While the global enable (configuration bit 0) is 0, `irq_out` stays low whatever is pending.
- R5: Writing to the in-service register clears each pending bit whose written bit is 1 and leaves the bits written 0 unchanged. If a source's request arrives in the same cycle as its clear, the bit stays pending.
- R6: A write with bit 0 = 1 to the vector register captures the highest-numbered enabled pending source. The source number reads back in bits [15:11]. The acknowledge leaves the pending register unchanged.
- R7: When configuration bits [12:8] hold a nonzero source number and that source is pending and enabled, an acknowledge captures that source ahead of any higher-numbered one.
- R8: The vector register holds its value until the next acknowledge. A write with bit 0 = 0 to the vector register does not change it.
- R9: An acknowledge with no enabled source pending captures vector 0.
- R10: A mask write that disables a source while that source is pending or requesting and enabled, with the global enable set, sets an error latch. The error latch keeps `irq_out` high. An acknowledge that finds no enabled source pending returns vector 0 and clears the latch.
- R11: Source 0 is reserved for the error vector. Its request input never sets a pending bit.
- R12: `irq_level` shows configuration bits [15:13].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_req | input | 32 | Request lines, one per source |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register select |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| irq_out | output | 1 | Level-sensitive interrupt to the core |
| irq_level | output | 3 | Priority level field |

## Verification
The bench drives a request and a clear for the same source in the same cycle. A design that lets the clear win would lose an interrupt that arrived while the previous one was being serviced.

The bench removes a source's enable while that source is pending. It expects the line to stay up and vector 0 to come back on the acknowledge. A design without the error latch would drop the line and leave software unaware that a request was lost.

The bench also checks three other cases:
- The favoured source beats a higher-numbered one. A design that ignores the override would return the wrong vector.
- The captured vector ignores requests that arrive after it. A design that tracks the live winner would return a changing vector.
- An acknowledge with nothing pending returns vector 0. A design without that default would return a stale vector.

// File: rtl/vpic_pkg.sv
// Shared constants for the interrupt controller: the register addresses
// and the positions of fields that both the design and its users decode.
package vpic_pkg;
    localparam logic [1:0] ADDR_CFG  = 2'd0;
    localparam logic [1:0] ADDR_MASK = 2'd1;
    localparam logic [1:0] ADDR_ISR  = 2'd2;
    localparam logic [1:0] ADDR_VEC  = 2'd3;

    localparam int CFG_EN_BIT  = 0;
    localparam int CFG_HP_LSB  = 8;
    localparam int CFG_LVL_LSB = 13;
    localparam int VEC_LSB     = 11;
    localparam int ACK_BIT     = 0;
endpackage

// File: rtl/vpic_regs.sv
// Configuration and mask storage.
// Holds the global enable, the favoured-source field, the priority level
// and the per-source mask. It reports which mask bits a mask write is
// turning from 1 to 0, so that the pending logic can detect a race.
// Assumes NUM_SRC <= 32 and that the field widths fit the bus.
module vpic_regs
    import vpic_pkg::*;
#(
    parameter int NUM_SRC = 32,
    parameter int VEC_W   = 5,
    parameter int LVL_W   = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_cfg,
    input  logic               wr_mask,
    input  logic [31:0]        wdata,
    output logic               cfg_en,
    output logic [VEC_W-1:0]   cfg_hp,
    output logic [LVL_W-1:0]   cfg_lvl,
    output logic [NUM_SRC-1:0] mask,
    output logic [NUM_SRC-1:0] mask_drop
);
    // Configuration register: write on address 0, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_en  <= 1'b0;
            cfg_hp  <= '0;
            cfg_lvl <= '0;
        end else if (wr_cfg) begin
            cfg_en  <= wdata[CFG_EN_BIT];
            cfg_hp  <= wdata[CFG_HP_LSB +: VEC_W];
            cfg_lvl <= wdata[CFG_LVL_LSB +: LVL_W];
        end
    end

    // Mask register: all sources are disabled after reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask <= '0;
        end else if (wr_mask) begin
            mask <= wdata[NUM_SRC-1:0];
        end
    end

    // Bits that the current mask write disables.
    always_comb begin
        mask_drop = wr_mask ? (mask & ~wdata[NUM_SRC-1:0]) : '0;
    end
endmodule

// File: rtl/vpic_pending.sv
// Pending-request latch and race error latch.
// A request sets its pending bit. The bit stays set until a write-one clear.
// A request that arrives in the same cycle as its clear wins. Source 0 is
// reserved and never pends. The error latch is set when a mask write
// disables a source that is pending or requesting under the global enable.
// It is cleared by an acknowledge that hands out the error vector.
module vpic_pending #(
    parameter int NUM_SRC = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_req,
    input  logic               clr_wr,
    input  logic [NUM_SRC-1:0] clr_bits,
    input  logic [NUM_SRC-1:0] mask_drop,
    input  logic               cfg_en,
    input  logic               err_take,
    output logic [NUM_SRC-1:0] pend,
    output logic               err
);
    localparam logic [NUM_SRC-1:0] VALID = {{(NUM_SRC-1){1'b1}}, 1'b0};

    logic [NUM_SRC-1:0] pend_nx;
    logic               race;

    // Next pending state: apply clears first, then new requests.
    always_comb begin
        pend_nx = ((pend & ~(clr_wr ? clr_bits : '0)) | src_req) & VALID;
        race    = cfg_en && ((mask_drop & (pend | src_req) & VALID) != '0);
    end

    // Pending register.
    always_ff @(posedge clk) begin
        if (!rst_n) pend <= '0;
        else        pend <= pend_nx;
    end

    // Error latch: a race sets it and wins over a clear in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)        err <= 1'b0;
        else if (race)     err <= 1'b1;
        else if (err_take) err <= 1'b0;
    end
endmodule

// File: rtl/vpic_vector.sv
// Priority selection and vector capture.
// The favoured source wins when it is active. Otherwise the highest-numbered
// active source wins. On an acknowledge the winner is frozen into the vector
// register, or vector 0 if nothing is active.
// Assumes bit 0 of 'active' is always 0.
module vpic_vector #(
    parameter int NUM_SRC = 32,
    parameter int VEC_W   = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] active,
    input  logic [VEC_W-1:0]   hp_sel,
    input  logic               ack,
    output logic [VEC_W-1:0]   vec,
    output logic               err_take
);
    logic [VEC_W-1:0] win;
    logic             hp_hit;

    // Winner search: later, higher indices overwrite earlier ones.
    always_comb begin
        win = '0;
        for (int i = 1; i < NUM_SRC; i++) begin
            if (active[i]) win = VEC_W'(i);
        end
        hp_hit = (hp_sel != '0) && (32'(hp_sel) < NUM_SRC) && active[hp_sel];
        if (hp_hit) win = hp_sel;
        err_take = ack && (active == '0);
    end

    // Vector register: changes only on an acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n)   vec <= '0;
        else if (ack) vec <= win;
    end
endmodule

// File: rtl/vpic_top.sv
// Top of the interrupt controller.
// Decodes the register bus, joins the configuration, pending and vector
// logic, and drives the level-sensitive output to the core.
// Reads are combinational on bus_addr. Writes take effect at the next edge.
module vpic_top
    import vpic_pkg::*;
#(
    parameter int NUM_SRC = 32,
    parameter int LVL_W   = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_req,
    input  logic               bus_wr,
    input  logic [1:0]         bus_addr,
    input  logic [31:0]        bus_wdata,
    output logic [31:0]        bus_rdata,
    output logic               irq_out,
    output logic [LVL_W-1:0]   irq_level
);
    localparam int VEC_W = $clog2(NUM_SRC);

    logic               wr_cfg, wr_mask, wr_isr, ack;
    logic               cfg_en, err, err_take;
    logic [VEC_W-1:0]   cfg_hp, vec;
    logic [NUM_SRC-1:0] mask, mask_drop, pend, active;

    // Write decode.
    always_comb begin
        wr_cfg  = bus_wr && (bus_addr == ADDR_CFG);
        wr_mask = bus_wr && (bus_addr == ADDR_MASK);
        wr_isr  = bus_wr && (bus_addr == ADDR_ISR);
        ack     = bus_wr && (bus_addr == ADDR_VEC) && bus_wdata[ACK_BIT];
    end

    vpic_regs #(.NUM_SRC(NUM_SRC), .VEC_W(VEC_W), .LVL_W(LVL_W)) regs_i (
        .clk(clk), .rst_n(rst_n), .wr_cfg(wr_cfg), .wr_mask(wr_mask),
        .wdata(bus_wdata), .cfg_en(cfg_en), .cfg_hp(cfg_hp),
        .cfg_lvl(irq_level), .mask(mask), .mask_drop(mask_drop)
    );

    vpic_pending #(.NUM_SRC(NUM_SRC)) pend_i (
        .clk(clk), .rst_n(rst_n), .src_req(src_req), .clr_wr(wr_isr),
        .clr_bits(bus_wdata[NUM_SRC-1:0]), .mask_drop(mask_drop),
        .cfg_en(cfg_en), .err_take(err_take), .pend(pend), .err(err)
    );

    // Enabled pending sources.
    always_comb active = pend & mask;

    vpic_vector #(.NUM_SRC(NUM_SRC), .VEC_W(VEC_W)) vec_i (
        .clk(clk), .rst_n(rst_n), .active(active), .hp_sel(cfg_hp),
        .ack(ack), .vec(vec), .err_take(err_take)
    );

    // Level output to the core.
    always_comb irq_out = cfg_en && ((active != '0) || err);

    // Read-back multiplexer.
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            ADDR_CFG: begin
                bus_rdata[CFG_EN_BIT]              = cfg_en;
                bus_rdata[CFG_HP_LSB +: VEC_W]     = cfg_hp;
                bus_rdata[CFG_LVL_LSB +: LVL_W]    = irq_level;
            end
            ADDR_MASK: bus_rdata[NUM_SRC-1:0]      = mask;
            ADDR_ISR:  bus_rdata[NUM_SRC-1:0]      = pend;
            default:   bus_rdata[VEC_LSB +: VEC_W] = vec;
        endcase
    end
endmodule

// File: rtl/vpic_chk.sv
// Checker for vpic_top. It watches the bus, the output and the internal
// state handed over by the bind below.
module vpic_chk
    import vpic_pkg::*;
#(
    parameter int NUM_SRC = 32,
    parameter int VEC_W   = 5
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_SRC-1:0] src_req,
    input logic               bus_wr,
    input logic [1:0]         bus_addr,
    input logic [31:0]        bus_wdata,
    input logic               irq_out,
    input logic               cfg_en,
    input logic [NUM_SRC-1:0] pend,
    input logic [NUM_SRC-1:0] mask,
    input logic [VEC_W-1:0]   vec
);
    assert_disabled_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_en |-> !irq_out);

    assert_src0_never_pends_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !pend[0]);

    assert_pending_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && bus_addr == ADDR_ISR) |=> ((pend & $past(pend)) == $past(pend)));

    assert_clear_applies_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_ISR) |=>
        ((pend & $past(bus_wdata[NUM_SRC-1:0] & ~src_req)) == '0));

    assert_vector_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && bus_addr == ADDR_VEC && bus_wdata[ACK_BIT]) |=> $stable(vec));

    assert_empty_ack_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_VEC && bus_wdata[ACK_BIT] && ((pend & mask) == '0))
        |=> (vec == '0));
endmodule

bind vpic_top vpic_chk #(.NUM_SRC(NUM_SRC), .VEC_W(VEC_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .src_req(src_req), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .irq_out(irq_out),
    .cfg_en(cfg_en), .pend(pend), .mask(mask), .vec(vec)
);

// File: tb/vpic_top_tb_top.sv
module vpic_top_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] src_req = '0;
    logic        bus_wr = 1'b0;
    logic [1:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_out;
    logic [2:0]  irq_level;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    vpic_top dut_i (
        .clk(clk), .rst_n(rst_n), .src_req(src_req), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_out(irq_out), .irq_level(irq_level)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic pulse(input logic [31:0] bits);
        @(negedge clk);
        src_req = bits;
        @(negedge clk);
        src_req = '0;
    endtask

    task automatic read_vec(output logic [31:0] v);
        logic [31:0] d;
        rd(2'd3, d);
        v = {27'd0, d[15:11]};
    endtask

    task automatic clear_all();
        wr(2'd2, 32'hFFFF_FFFF);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        rd(2'd0, d); check("R1 cfg", d, 0);
        rd(2'd1, d); check("R1 mask", d, 0);
        rd(2'd2, d); check("R1 pend", d, 0);
        rd(2'd3, d); check("R1 vec", d, 0);
        check("R1 irq", irq_out, 0);
    endtask

    task automatic t_pending();
        logic [31:0] d;
        wr(2'd0, 32'h1);
        pulse(32'h20);
        rd(2'd2, d); check("R2 masked source latched", d, 32'h20);
        check("R3 masked pending gives no irq", irq_out, 0);
        wr(2'd1, 32'h20);
        check("R3 enabled pending raises irq", irq_out, 1);
        repeat (3) @(negedge clk);
        check("R3 irq level held", irq_out, 1);
        wr(2'd2, 32'h0);
        rd(2'd2, d); check("R5 zero write keeps pending", d, 32'h20);
        wr(2'd2, 32'h20);
        rd(2'd2, d); check("R5 one write clears", d, 0);
        check("R3 irq drops after clear", irq_out, 0);
    endtask

    task automatic t_enable();
        wr(2'd0, 32'h0);
        pulse(32'h20);
        check("R4 disabled blocks irq", irq_out, 0);
        wr(2'd0, 32'h1);
        check("R4 enable releases irq", irq_out, 1);
        clear_all();
    endtask

    task automatic t_same_cycle();
        logic [31:0] d;
        pulse(32'h1000);
        @(negedge clk);
        src_req = 32'h1000; bus_wr = 1'b1; bus_addr = 2'd2; bus_wdata = 32'h1000;
        @(negedge clk);
        src_req = '0; bus_wr = 1'b0; bus_wdata = '0;
        rd(2'd2, d); check("R5 request beats clear", d, 32'h1000);
        clear_all();
    endtask

    task automatic t_ack();
        logic [31:0] d;
        wr(2'd1, 32'hFFEF_FFFF);
        pulse(32'h0010_0208);
        wr(2'd3, 32'h1);
        read_vec(d); check("R6 highest enabled wins", d, 9);
        rd(2'd2, d); check("R6 ack keeps pending", d, 32'h0010_0208);
        clear_all();
    endtask

    task automatic t_hp();
        logic [31:0] d;
        wr(2'd1, 32'hFFFF_FFFF);
        wr(2'd0, 32'h0000_0401);
        pulse(32'h4000_0010);
        wr(2'd3, 32'h1);
        read_vec(d); check("R7 favoured source wins", d, 4);
        wr(2'd2, 32'h10);
        wr(2'd3, 32'h1);
        read_vec(d); check("R7 favoured idle, highest wins", d, 30);
        wr(2'd0, 32'h1);
        clear_all();
    endtask

    task automatic t_hold();
        logic [31:0] d;
        pulse(32'h100);
        wr(2'd3, 32'h1);
        pulse(32'h8000_0000);
        read_vec(d); check("R8 vector held", d, 8);
        wr(2'd3, 32'h0);
        read_vec(d); check("R8 non-ack write ignored", d, 8);
        wr(2'd3, 32'h1);
        read_vec(d); check("R8 next ack updates", d, 31);
        clear_all();
    endtask

    task automatic t_empty();
        logic [31:0] d;
        pulse(32'h40);
        wr(2'd3, 32'h1);
        clear_all();
        wr(2'd3, 32'h1);
        read_vec(d); check("R9 empty ack gives 0", d, 0);
    endtask

    task automatic t_race();
        logic [31:0] d;
        wr(2'd1, 32'h80);
        pulse(32'h80);
        pulse(32'h200);
        wr(2'd3, 32'h1);
        read_vec(d); check("R10 setup vector", d, 7);
        wr(2'd1, 32'h0);
        check("R10 error holds irq", irq_out, 1);
        wr(2'd3, 32'h1);
        read_vec(d); check("R10 error vector", d, 0);
        check("R10 ack clears error", irq_out, 0);
        clear_all();
    endtask

    task automatic t_src0();
        logic [31:0] d;
        pulse(32'h1);
        rd(2'd2, d); check("R11 source 0 ignored", d, 0);
    endtask

    task automatic t_level();
        wr(2'd0, 32'h0000_A001);
        check("R12 level output", {29'd0, irq_level}, 5);
        wr(2'd0, 32'h1);
    endtask

    bit done = 0;

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_pending();
        t_enable();
        t_same_cycle();
        t_ack();
        t_hp();
        t_hold();
        t_empty();
        t_race();
        t_src0();
        t_level();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule